// File: doc/BRIEF.md
# Prioritized Pending Interrupt Selector

This block holds one pending flag for each of fourteen interrupt sources and, in every cycle where the core says it can accept an interrupt, names the single source to take. Sources rank in a fixed order. Each rank is gated by an enable from the machine state. The result appears in the same cycle as an encoded code and as a one-hot vector, together with a valid strobe. The caller then performs vector lookup, state saving and machine-state update.

Most sources are edge-type. A one-cycle pulse on the source line sets the flag, and taking the source clears the flag again. The critical external source and the external source are level-type. Their flag follows the source line, so taking one of them leaves it pending until the source drops the line.

Top module: `irq_sel_top`

## Requirements
- R1: After reset no flag is pending, and takeValid stays low until a source line is raised.
- R2: Sources rank from highest to lowest with these takeCode values: 0 system reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. The lowest eligible pending code wins. takeOneHot has bit N set exactly when code N is taken. Source line N is bit N of srcSet.
- R3: A pending system reset (code 0) is taken whenever coreReady is high, whatever the enables are.
- R4: Machine check (code 1) is eligible only while enMchk is high.
- R5: Debug, critical external, watchdog and critical doorbell (codes 2, 4, 5, 6) are eligible only while enCrit is high.
- R6: Codes 7 through 13 are eligible only while enExt is high.
- R7: The hypervisor decrementer (code 3) is eligible only while enHdec is high and at least one of these holds: enExt is high, hvState is low, probState is high.
- R8: At most one source is taken per cycle. takeValid is low when coreReady is low or when no eligible source is pending.
- R9: An edge-type source, meaning any code other than 4 and 10, has its flag cleared at the clock edge that ends the cycle in which it is taken.
- R10: The flags for codes 4 and 10 equal the value their source lines held at the previous clock edge. Taking one of them does not clear it.
- R11: If an edge-type source line is high in the cycle its flag is taken, the flag remains set.
- R12: A source line sampled high at a clock edge makes that flag pending, and it can be taken, in the cycle that starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcSet | input | 14 | Source lines: set pulses for edge-type sources, levels for codes 4 and 10 |
| coreReady | input | 1 | The core can take an interrupt in this cycle |
| enMchk | input | 1 | Machine-check enable |
| enCrit | input | 1 | Critical-class enable |
| enExt | input | 1 | External-class enable |
| enHdec | input | 1 | Hypervisor-decrementer enable |
| hvState | input | 1 | Hypervisor state bit |
| probState | input | 1 | Problem (user) state bit |
| takeValid | output | 1 | A source is taken in this cycle |
| takeCode | output | 4 | Encoded code of the taken source |
| takeOneHot | output | 14 | One-hot form of the taken source |

## Verification
The first directed pattern raises every source at once with all enables high and then drains the flags. The taken codes must follow the rank order, and a held level source must be taken again and again so that it blocks every lower rank until its line falls. Further directed patterns check each enable in isolation. They also cover every combination of the hypervisor-decrementer condition and a pulse that arrives in the same cycle its flag is taken, which separates set-wins from clear-wins. A long random run then draws sparse pulses, levels, enables and ready, and compares every cycle with a reference priority model kept in the bench. This run exposes rank swaps, wrong gating tiers and mishandled level sources.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam int NUM_SRC = 14;
  localparam int CODE_W  = $clog2(NUM_SRC);

  // Index doubles as rank: lower index means higher priority.
  typedef enum logic [CODE_W-1:0] {
    SRC_SYSRST = 4'd0,
    SRC_MCHK   = 4'd1,
    SRC_DEBUG  = 4'd2,
    SRC_HDEC   = 4'd3,
    SRC_CEXT   = 4'd4,
    SRC_WDOG   = 4'd5,
    SRC_CBELL  = 4'd6,
    SRC_FIT    = 4'd7,
    SRC_PIT    = 4'd8,
    SRC_DEC    = 4'd9,
    SRC_EXT    = 4'd10,
    SRC_BELL   = 4'd11,
    SRC_PERF   = 4'd12,
    SRC_THERM  = 4'd13
  } srcId_e;

  localparam logic [NUM_SRC-1:0] LEVEL_MASK =
    (NUM_SRC'(1) << SRC_CEXT) | (NUM_SRC'(1) << SRC_EXT);

  // Strobes from control to datapath.
  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] takeOneHot;
  } selStrobe_t;

  // Machine-state gating bits.
  typedef struct packed {
    logic mchk;
    logic crit;
    logic ext;
    logic hdec;
    logic hv;
    logic prob;
  } gateBits_t;
endpackage

// File: rtl/irq_sel_pend.sv
module irq_sel_pend
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  selStrobe_t         strobe,
  output logic [NUM_SRC-1:0] pendQ
);
  logic [NUM_SRC-1:0] clrMask;
  logic [NUM_SRC-1:0] pendNext;
  logic               armQ;

  assign clrMask = strobe.take ? strobe.takeOneHot : '0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      assign pendNext[i] = srcSet[i];
    end else begin : g_edge
      assign pendNext[i] = (pendQ[i] & ~clrMask[i]) | srcSet[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      armQ  <= 1'b0;
    end else begin
      pendQ <= pendNext;
      armQ  <= 1'b1;
    end
  end

  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> ((pendQ & $past(strobe.takeOneHot & ~srcSet & ~LEVEL_MASK)) == '0)); // R9
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((pendQ & LEVEL_MASK) == ($past(srcSet) & LEVEL_MASK))); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> ((pendQ & $past(srcSet & ~LEVEL_MASK)) == $past(srcSet & ~LEVEL_MASK))); // R11
endmodule

// File: rtl/irq_sel_ctrl.sv
module irq_sel_ctrl
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendQ,
  input  gateBits_t          gate,
  input  logic               coreReady,
  output selStrobe_t         strobe,
  output logic [CODE_W-1:0]  takeCode
);
  logic [NUM_SRC-1:0] enableMask;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] oneHot;
  logic               hdecOk;

  assign hdecOk = gate.hdec & (gate.ext | ~gate.hv | gate.prob);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
    if (i == SRC_SYSRST) begin : g_rst
      assign enableMask[i] = 1'b1;
    end else if (i == SRC_MCHK) begin : g_mchk
      assign enableMask[i] = gate.mchk;
    end else if (i == SRC_HDEC) begin : g_hdec
      assign enableMask[i] = hdecOk;
    end else if (i < SRC_FIT) begin : g_crit
      assign enableMask[i] = gate.crit;
    end else begin : g_ext
      assign enableMask[i] = gate.ext;
    end
  end

  assign cand   = coreReady ? (pendQ & enableMask) : '0;
  assign oneHot = cand & ~(cand - NUM_SRC'(1));

  always_comb begin
    takeCode = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (oneHot[i]) takeCode = CODE_W'(i);
    end
  end

  assign strobe.take       = |cand;
  assign strobe.takeOneHot = oneHot;

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.takeOneHot)); // R8
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !coreReady |-> !strobe.take); // R8
  AST_SYSRST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ[SRC_SYSRST] && coreReady) |-> (strobe.take && takeCode == SRC_SYSRST)); // R3
  AST_MCHK_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && takeCode == SRC_MCHK) |-> gate.mchk); // R4
  AST_CRIT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && (takeCode == SRC_DEBUG || takeCode == SRC_CEXT ||
     takeCode == SRC_WDOG || takeCode == SRC_CBELL)) |-> gate.crit); // R5
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && takeCode >= SRC_FIT) |-> gate.ext); // R6
  AST_HDEC_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && takeCode == SRC_HDEC) |->
      (gate.hdec && (gate.ext || !gate.hv || gate.prob))); // R7
endmodule

// File: rtl/irq_sel_top.sv
module irq_sel_top
  import irq_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic               coreReady,
  input  logic               enMchk,
  input  logic               enCrit,
  input  logic               enExt,
  input  logic               enHdec,
  input  logic               hvState,
  input  logic               probState,
  output logic               takeValid,
  output logic [CODE_W-1:0]  takeCode,
  output logic [NUM_SRC-1:0] takeOneHot
);
  logic [NUM_SRC-1:0] pendQ;
  selStrobe_t         strobe;
  gateBits_t          gate;

  assign gate = '{mchk: enMchk, crit: enCrit, ext: enExt,
                  hdec: enHdec, hv: hvState, prob: probState};

  irq_sel_pend pend_i (
    .clk    (clk),
    .rstN   (rstN),
    .srcSet (srcSet),
    .strobe (strobe),
    .pendQ  (pendQ)
  );

  irq_sel_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .pendQ     (pendQ),
    .gate      (gate),
    .coreReady (coreReady),
    .strobe    (strobe),
    .takeCode  (takeCode)
  );

  assign takeValid  = strobe.take;
  assign takeOneHot = strobe.takeOneHot;
endmodule

// File: tb/irq_sel_top_tb_top.sv
module irq_sel_top_tb_top;
  localparam int PERIOD = 10;
  localparam int NSRC   = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcSet = '0;
  logic            coreReady = 1'b0;
  logic            enMchk = 1'b0, enCrit = 1'b0, enExt = 1'b0, enHdec = 1'b0;
  logic            hvState = 1'b0, probState = 1'b0;
  logic            takeValid;
  logic [3:0]      takeCode;
  logic [NSRC-1:0] takeOneHot;

  int checks = 0;
  int errors = 0;
  logic [NSRC-1:0] modelPend = '0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #(PERIOD/2) clk = ~clk;

  irq_sel_top dut_i (
    .clk(clk), .rstN(rstN), .srcSet(srcSet), .coreReady(coreReady),
    .enMchk(enMchk), .enCrit(enCrit), .enExt(enExt), .enHdec(enHdec),
    .hvState(hvState), .probState(probState),
    .takeValid(takeValid), .takeCode(takeCode), .takeOneHot(takeOneHot)
  );

  function automatic bit allowed(int i, bit m, bit c, bit e, bit h, bit hv, bit pr);
    case (i)
      0:          return 1'b1;
      1:          return m;
      3:          return h && (e || !hv || pr);
      2, 4, 5, 6: return c;
      default:    return e;
    endcase
  endfunction

  function automatic bit isLevel(int i);
    return (i == 4) || (i == 10);
  endfunction

  // Driver: apply one cycle of stimulus, push the expected selection.
  task automatic step(input logic [NSRC-1:0] s, input bit rdy, input bit m, input bit c,
                      input bit e, input bit h, input bit hv, input bit pr, input string tag);
    bit found = 0;
    int code = 0;
    @(negedge clk);
    srcSet = s; coreReady = rdy; enMchk = m; enCrit = c; enExt = e;
    enHdec = h; hvState = hv; probState = pr;
    if (rdy) begin
      for (int i = 0; i < NSRC; i++) begin
        if (!found && modelPend[i] && allowed(i, m, c, e, h, hv, pr)) begin
          found = 1; code = i;
        end
      end
    end
    expQ.push_back({found, 4'(code)});
    tagQ.push_back(tag);
    for (int i = 0; i < NSRC; i++) begin
      if (isLevel(i)) modelPend[i] = s[i];
      else modelPend[i] = (modelPend[i] && !(found && code == i)) || s[i];
    end
  endtask

  // Monitor: compare the design against the queue away from the edge.
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [4:0] exp_item;
      string tag;
      logic [NSRC-1:0] expHot;
      exp_item = expQ.pop_front();
      tag = tagQ.pop_front();
      expHot = exp_item[4] ? (NSRC'(1) << exp_item[3:0]) : '0;
      checks++;
      if (takeValid !== exp_item[4] || (exp_item[4] && takeCode !== exp_item[3:0]) ||
          takeOneHot !== expHot) begin
        errors++;
        $display("FAIL %s: valid=%0b code=%0d hot=%h, expected valid=%0b code=%0d hot=%h",
                 tag, takeValid, takeCode, takeOneHot, exp_item[4], exp_item[3:0], expHot);
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [NSRC-1:0] all = '1;
    repeat (3) @(negedge clk);
    // R1: reset state observed while still in reset, then after release
    checks++;
    if (takeValid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b during reset, expected 0", takeValid);
    end
    rstN = 1'b1;
    step('0, 1, 1, 1, 1, 1, 0, 0, "R1");
    step('0, 1, 1, 1, 1, 1, 0, 0, "R1");

    // R12 and R8: pulse everything, not ready yet
    step(all, 0, 1, 1, 1, 1, 0, 0, "R8");
    // R2 with R12: drain in rank order, level code 4 held high
    step(14'h0410, 1, 1, 1, 1, 1, 0, 0, "R12");
    repeat (4) step(14'h0410, 1, 1, 1, 1, 1, 0, 0, "R2");
    // R10: code 4 stays and blocks lower ranks
    repeat (2) step(14'h0410, 1, 1, 1, 1, 1, 0, 0, "R10");
    // drop code 4 line; code 10 still held
    repeat (6) step(14'h0400, 1, 1, 1, 1, 1, 0, 0, "R2");
    repeat (2) step(14'h0400, 1, 1, 1, 1, 1, 0, 0, "R10");
    repeat (4) step('0, 1, 1, 1, 1, 1, 0, 0, "R9");

    // R3: reset source with every enable low
    step(14'h0001, 0, 0, 0, 0, 0, 1, 0, "R3");
    step('0, 1, 0, 0, 0, 0, 1, 0, "R3");
    step('0, 1, 0, 0, 0, 0, 1, 0, "R9");

    // R4: machine check gated
    step(14'h0002, 1, 0, 1, 1, 1, 0, 0, "R4");
    step('0, 1, 0, 1, 1, 1, 0, 0, "R4");
    step('0, 1, 1, 1, 1, 1, 0, 0, "R4");

    // R5: critical tier gated, lower external tier still taken
    step(14'h00E4, 1, 1, 0, 1, 1, 0, 0, "R5");
    step('0, 1, 1, 0, 1, 1, 0, 0, "R5");
    step('0, 1, 1, 0, 1, 1, 0, 0, "R5");
    repeat (3) step('0, 1, 1, 1, 1, 1, 0, 0, "R5");

    // R6: external tier gated
    step(14'h3F80, 1, 1, 1, 0, 1, 0, 0, "R6");
    step('0, 1, 1, 1, 0, 1, 0, 0, "R6");
    repeat (6) step('0, 1, 1, 1, 1, 1, 0, 0, "R6");

    // R7: every combination of the hypervisor decrementer condition
    for (int k = 0; k < 16; k++) begin
      step(14'h0008, 0, 1, 1, k[0], k[1], k[2], k[3], "R7");
      step('0, 1, 1, 1, k[0], k[1], k[2], k[3], "R7");
      step('0, 1, 1, 1, 1, 1, 0, 0, "R7");
    end

    // R11: pulse arrives while the same flag is taken
    step(14'h2000, 1, 1, 1, 1, 1, 0, 0, "R11");
    step(14'h2000, 1, 1, 1, 1, 1, 0, 0, "R11");
    step('0, 1, 1, 1, 1, 1, 0, 0, "R11");
    step('0, 1, 1, 1, 1, 1, 0, 0, "R9");

    // Random run against the reference model
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] s = '0;
      for (int i = 0; i < NSRC; i++) begin
        if (isLevel(i)) s[i] = ($urandom % 3 == 0);
        else s[i] = ($urandom % 10 == 0);
      end
      step(s, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, $urandom % 2, $urandom % 2, "R2");
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule